// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that drives two pulse-width outputs from one shared up-counter. The counter advances on ticks taken from a prescaler. The prescaler divides the system clock by 2, 8, 32 or 128, or it follows pulses on a slow-clock strobe input. The counter returns to zero on the tick where it equals the period register. Output A reacts to a match against its own compare register, and output B does the same with a second compare register. Both outputs also react to the period match and to a software trigger. For each output and each event, the mode register selects one action: keep, set, clear or toggle.

Software sets up the channel through a small write-only register port. That port holds a mode word, two compare values, the period value and a command strobe. The command strobe starts or stops the tick stream. It can also fire a software trigger, which zeroes the counter, restarts the prescaler and applies each output's trigger action. A 0 % or 100 % output is made by programming no compare or period actions, so that the level forced by the trigger stays in place. Normal polarity sets the output on the period match and clears it on the compare match. Inverted polarity does the reverse.

Top module: `tmr_dual_pwm`

## Requirements
- R1: After reset, out_a and out_b are low, count is 0, the tick stream is stopped, and every register reads as zero.
- R2: On each tick the counter adds one. On a tick where count equals the period register it returns to 0 instead, so one period lasts period+1 ticks.
- R3: Mode bits [3:1] choose the tick source: 0 gives clk/2, 1 gives clk/8, 2 gives clk/32, 3 gives clk/128, and 4 to 7 take one tick per cycle in which slow_tick is high. Ticks occur only while the tick stream is started and bit 0 is set.
- R4: Each action is a 2-bit code: 00 keep, 01 set, 10 clear, 11 toggle. Output A takes its compare action from mode[5:4], its period action from mode[7:6] and its trigger action from mode[9:8]. Output B uses mode[11:10], mode[13:12] and mode[15:14] for the same three events.
- R5: A compare event for output A is a tick on which count equals the A compare register, and output B uses the B compare register in the same way. With clear on compare and set on period, an output is high for compare+1 of every period+1 ticks. With the actions swapped it is high for period-compare ticks.
- R6: The register addresses are 0 for mode, 1 for A compare, 2 for B compare, 3 for period and 4 for command. Writes to addresses 5 to 7 are ignored. Command bit 0 starts ticks and bit 1 stops them; if both are set, stop wins. Command bit 2 is the software trigger: in that same clock edge it zeroes count, restarts the prescaler and applies each output's trigger action.
- R7: While ticks are stopped, count and both outputs hold their values.
- R8: An output with keep programmed for both its compare and period actions stays at the level set by the last software trigger. This gives a constant high or a constant low.
- R9: When events coincide on one output, only the highest-priority one acts. The software trigger comes first, then the period match, then the compare match.
- R10: While mode bit 0 is clear, count is held at 0, both outputs are held low and software triggers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | WIDTH | Write data; compare and period registers take all WIDTH bits, mode takes [15:0], command takes [2:0] |
| slow_tick | input | 1 | Slow-clock strobe, one cycle high per slow period |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | WIDTH | Current counter value |

## Verification
The bench builds the block with WIDTH set to 16. At that width small period values give waveforms of a few dozen to a few hundred clocks, so every prescaler tap can be measured over whole periods, including divide-by-128 and the slow strobe. High time and rising edges are counted over exact multiples of the period. The result therefore does not depend on phase, yet an off-by-one in a compare or in the wrap still shows up. Directed cases then create the coincident events, the stopped clock and the disabled waveform mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // packed MSB first: trigger [5:4], period [3:2], compare [1:0]
  typedef struct packed {
    act_e on_sw;
    act_e on_per;
    act_e on_cmp;
  } out_act_t;

  typedef struct packed {
    out_act_t act_b;    // [15:10]
    out_act_t act_a;    // [9:4]
    logic [2:0] clk_sel; // [3:1]
    logic wave_en;      // [0]
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_CMPB = 3'd2;
  localparam logic [2:0] ADDR_PER  = 3'd3;
  localparam logic [2:0] ADDR_CMD  = 3'd4;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_TRIG  = 2;

  function automatic logic apply_act(input logic cur, input act_e act);
    case (act)
      ACT_SET:  return 1'b1;
      ACT_CLR:  return 1'b0;
      ACT_TGL:  return ~cur;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int NUM_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);
  localparam int PRE_W = 2 * NUM_DIV - 1;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] tap_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (run)     pre_q <= pre_q + 1'b1;
  end

  // tap i fires once every 2^(2i+1) cycles
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    assign tap_hit[i] = &pre_q[2*i:0];
  end

  always_comb begin
    if (!run)        tick = 1'b0;
    else if (sel[2]) tick = slow_tick;
    else             tick = tap_hit[sel[1:0]];
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int WIDTH = 32,
  parameter int NCMP  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       clear,
  input  logic [WIDTH-1:0]           per_val,
  input  logic [NCMP-1:0][WIDTH-1:0] cmp_val,
  output logic [WIDTH-1:0]           cnt,
  output logic                       per_hit,
  output logic [NCMP-1:0]            cmp_hit
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  assign per_hit = tick && (cnt == per_val);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign cmp_hit[i] = tick && (cnt == cmp_val[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (per_hit) cnt <= '0;
    else if (tick)    cnt <= cnt + ONE;
  end

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hold_low,
  input  logic     sw_hit,
  input  logic     per_hit,
  input  logic     cmp_hit,
  input  out_act_t act,
  output logic     wave
);
  always_ff @(posedge clk) begin
    if (!rst_n)        wave <= 1'b0;
    else if (hold_low) wave <= 1'b0;
    else if (sw_hit)   wave <= apply_act(wave, act.on_sw);
    else if (per_hit)  wave <= apply_act(wave, act.on_per);
    else if (cmp_hit)  wave <= apply_act(wave, act.on_cmp);
  end

endmodule

// File: rtl/tmr_dual_pwm.sv
module tmr_dual_pwm
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             slow_tick,
  output logic             out_a,
  output logic             out_b,
  output logic [WIDTH-1:0] count
);
  localparam int NUM_OUT = 2;

  mode_t                         mode_q;
  logic [NUM_OUT-1:0][WIDTH-1:0] cmp_q;
  logic [WIDTH-1:0]              per_q;
  logic                          clk_on_q;

  logic                          cmd_wr;
  logic                          sw_fire;
  logic                          run;
  logic                          tick;
  logic                          per_hit;
  logic [NUM_OUT-1:0]            cmp_hit;
  logic [NUM_OUT-1:0]            wave;
  out_act_t                      acts [NUM_OUT];

  assign cmd_wr  = wr_en && (wr_addr == ADDR_CMD);
  assign sw_fire = cmd_wr && wr_data[CMD_TRIG] && mode_q.wave_en;
  assign run     = clk_on_q && mode_q.wave_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cmp_q    <= '0;
      per_q    <= '0;
      clk_on_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_MODE: mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        ADDR_CMPA: cmp_q[0] <= wr_data;
        ADDR_CMPB: cmp_q[1] <= wr_data;
        ADDR_PER:  per_q    <= wr_data;
        ADDR_CMD: begin
          if (wr_data[CMD_STOP])       clk_on_q <= 1'b0;
          else if (wr_data[CMD_START]) clk_on_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  tmr_prescale #(.NUM_DIV(4)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .restart   (sw_fire),
    .sel       (mode_q.clk_sel),
    .slow_tick (slow_tick),
    .tick      (tick)
  );

  tmr_counter #(.WIDTH(WIDTH), .NCMP(NUM_OUT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clear   (sw_fire || !mode_q.wave_en),
    .per_val (per_q),
    .cmp_val (cmp_q),
    .cnt     (count),
    .per_hit (per_hit),
    .cmp_hit (cmp_hit)
  );

  assign acts[0] = mode_q.act_a;
  assign acts[1] = mode_q.act_b;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    tmr_wave_out u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_low (!mode_q.wave_en),
      .sw_hit   (sw_fire),
      .per_hit  (per_hit),
      .cmp_hit  (cmp_hit[i]),
      .act      (acts[i]),
      .wave     (wave[i])
    );
  end

  assign out_a = wave[0];
  assign out_b = wave[1];

endmodule

// File: rtl/tmr_dual_pwm_chk.sv
module tmr_dual_pwm_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wave_en,
  input logic [1:0]       a_sw_act,
  input logic [1:0]       b_sw_act,
  input logic             clk_on,
  input logic             cmd_wr,
  input logic             sw_fire,
  input logic             tick,
  input logic             per_hit,
  input logic [WIDTH-1:0] count,
  input logic             out_a,
  input logic             out_b
);
  // R2: the period match returns the counter to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (per_hit && !sw_fire && wave_en) |=> (count == '0));

  // R2: a plain tick adds exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !per_hit && !sw_fire && wave_en) |=> (count == WIDTH'($past(count) + 1'b1)));

  // R3: no tick while stopped or with waveform mode off
  a_r3_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (clk_on && wave_en));

  // R6: the software trigger zeroes the counter
  a_r6_trig_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> (count == '0));

  // R7: stopped ticks hold the counter and both outputs
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !cmd_wr && wave_en) |=> ($stable(count) && $stable(out_a) && $stable(out_b)));

  // R9: the trigger action wins over any coincident event
  a_r9_trig_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fire && a_sw_act == 2'b01) |=> out_a);
  a_r9_trig_clr_b: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fire && b_sw_act == 2'b10) |=> !out_b);

  // R10: waveform mode off forces zero count and low outputs
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_en |=> (count == '0 && !out_a && !out_b));

endmodule

bind tmr_dual_pwm tmr_dual_pwm_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wave_en  (mode_q.wave_en),
  .a_sw_act (mode_q.act_a.on_sw),
  .b_sw_act (mode_q.act_b.on_sw),
  .clk_on   (clk_on_q),
  .cmd_wr   (cmd_wr),
  .sw_fire  (sw_fire),
  .tick     (tick),
  .per_hit  (per_hit),
  .count    (count),
  .out_a    (out_a),
  .out_b    (out_b)
);

// File: tb/tb_tmr_dual_pwm.sv
module tb_tmr_dual_pwm;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         slow_tick = 1'b0;
  logic         out_a, out_b;
  logic [W-1:0] count;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tmr_dual_pwm #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slow_tick(slow_tick),
    .out_a(out_a), .out_b(out_b), .count(count)
  );

  // slow strobe: one cycle high in every five
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk(input logic en, input logic [2:0] sel,
      input logic [1:0] ac, input logic [1:0] ap, input logic [1:0] as_,
      input logic [1:0] bc, input logic [1:0] bp, input logic [1:0] bs);
    return {bs, bp, bc, as_, ap, ac, sel, en};
  endfunction

  localparam logic [2:0] A_MODE = 3'd0, A_CA = 3'd1, A_CB = 3'd2, A_PER = 3'd3, A_CMD = 3'd4;
  localparam logic [W-1:0] C_START = 16'd1, C_STOP = 16'd2, C_TRIG = 16'd4;

  // table: sel, A compare, B compare, period, A inverted, period in clocks, A highs, B highs
  localparam int NV = 6;
  localparam int T_SEL [NV] = '{0, 1, 0, 2, 4, 3};
  localparam int T_RA  [NV] = '{3, 1, 6, 0, 2, 0};
  localparam int T_RB  [NV] = '{0, 3, 2, 1, 4, 0};
  localparam int T_RC  [NV] = '{9, 4, 7, 2, 5, 1};
  localparam int T_INV [NV] = '{0, 0, 1, 0, 0, 0};
  localparam int T_P   [NV] = '{20, 40, 16, 96, 30, 256};
  localparam int T_HA  [NV] = '{8, 16, 2, 32, 15, 128};
  localparam int T_HB  [NV] = '{2, 32, 6, 64, 25, 128};

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] held_c;
    logic held_a, held_b;
    int ha, hb, rises;
    logic prev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_a == 0 && out_b == 0, "R1 outputs low after reset", {out_a, out_b}, 0);
    chk(count == 0, "R1 count zero after reset", count, 0);
    // R1: tick stream stopped at reset, so waveform mode alone does not count
    wr(A_MODE, W'(mk(1, 0, 0, 0, 0, 0, 0, 0)));
    wr(A_PER, 16'd50);
    repeat (20) @(negedge clk);
    chk(count == 0, "R1 clock stopped after reset", count, 0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      if (T_INV[i] != 0)
        wr(A_MODE, W'(mk(1, 3'(T_SEL[i]), 2'b01, 2'b10, 2'b10, 2'b10, 2'b01, 2'b01)));
      else
        wr(A_MODE, W'(mk(1, 3'(T_SEL[i]), 2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01)));
      wr(A_CA, W'(T_RA[i]));
      wr(A_CB, W'(T_RB[i]));
      wr(A_PER, W'(T_RC[i]));
      wr(A_CMD, C_START | C_TRIG);
      repeat (2 * T_P[i]) @(negedge clk);
      ha = 0; hb = 0;
      for (int k = 0; k < T_P[i]; k++) begin
        @(negedge clk);
        ha += int'(out_a); hb += int'(out_b);
      end
      chk(ha == T_HA[i], $sformatf("R5 R3 vector %0d A high time", i), ha, T_HA[i]);
      chk(hb == T_HB[i], $sformatf("R5 R3 vector %0d B high time", i), hb, T_HB[i]);
      rises = 0; prev = out_a;
      for (int k = 0; k < 2 * T_P[i]; k++) begin
        @(negedge clk);
        if (out_a && !prev) rises++;
        prev = out_a;
      end
      chk(rises == 2, $sformatf("R2 vector %0d A period", i), rises, 2);
    end

    // R10: waveform mode off holds everything low and ignores the trigger
    wr(A_MODE, W'(mk(0, 0, 0, 0, 2'b01, 0, 0, 2'b01)));
    wr(A_CMD, C_START | C_TRIG);
    repeat (20) @(negedge clk);
    chk(count == 0, "R10 count held at zero", count, 0);
    chk(out_a == 0 && out_b == 0, "R10 outputs low, trigger ignored", {out_a, out_b}, 0);

    // R6 R8: trigger with ticks stopped, then constant levels with keep actions
    wr(A_CMD, C_STOP);
    wr(A_MODE, W'(mk(1, 0, 0, 0, 2'b01, 0, 0, 2'b10)));
    wr(A_PER, 16'd100);
    wr(A_CMD, C_TRIG);
    chk(out_a == 1 && out_b == 0, "R6 trigger levels applied", {out_a, out_b}, 2);
    chk(count == 0, "R6 trigger zeroes count", count, 0);
    wr(A_CMD, C_START);
    repeat (21) @(negedge clk);
    chk(count != 0, "R6 start makes counter run", count, 1);
    chk(out_a == 1, "R8 constant high held", out_a, 1);
    chk(out_b == 0, "R8 constant low held", out_b, 0);
    wr(A_CMD, C_TRIG);
    chk(count == 0, "R6 running trigger zeroes count", count, 0);

    // R7: stop holds state; R6: start plus stop means stop
    repeat (7) @(negedge clk);
    wr(A_CMD, C_STOP);
    held_c = count; held_a = out_a; held_b = out_b;
    repeat (30) @(negedge clk);
    chk(count == held_c, "R7 count held while stopped", count, held_c);
    chk(out_a == held_a && out_b == held_b, "R7 outputs held while stopped", {out_a, out_b}, {held_a, held_b});
    wr(A_CMD, C_START | C_STOP);
    repeat (30) @(negedge clk);
    chk(count == held_c, "R6 stop wins over start", count, held_c);

    // R9: period match outranks a coincident compare match
    wr(A_MODE, W'(mk(1, 0, 2'b10, 2'b01, 2'b10, 0, 0, 0)));
    wr(A_CA, 16'd3);
    wr(A_PER, 16'd3);
    wr(A_CMD, C_START | C_TRIG);
    repeat (30) @(negedge clk);
    ha = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ha += int'(out_a);
    end
    chk(ha == 8, "R9 period beats compare", ha, 8);

    // R9: trigger outranks a coincident period match (period 0, tick every 2 clocks)
    wr(A_MODE, W'(mk(1, 0, 2'b00, 2'b01, 2'b10, 0, 0, 0)));
    wr(A_PER, 16'd0);
    wr(A_CMD, C_START | C_TRIG);
    wr(A_CMD, C_START | C_TRIG);
    chk(out_a == 0, "R9 trigger beats period", out_a, 0);

    // R4: toggle on compare gives half duty over two periods
    wr(A_MODE, W'(mk(1, 0, 2'b11, 2'b00, 2'b10, 0, 0, 0)));
    wr(A_CA, 16'd2);
    wr(A_PER, 16'd4);
    wr(A_CMD, C_START | C_TRIG);
    repeat (20) @(negedge clk);
    ha = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      ha += int'(out_a);
    end
    chk(ha == 10, "R4 toggle action", ha, 10);

    finish_run();
  end

endmodule